// File: doc/BRIEF.md
# Interleaved I/Q Sample Serializer

This block carries received baseband samples to a signal processor while a burst is being received. Each sample pair arrives as one strobe with a 15-bit in-phase value and a 15-bit quadrature value. The block packs each value into a 16-bit word. The upper fifteen bits hold the sample and the lowest bit says which component it is. It then shifts the in-phase word and the quadrature word out back to back, one bit per master clock.

Pairs arrive at the symbol rate, about once every 48 master clocks. Sending a pair takes 32 bit times plus one sync cycle, so the serial line is quiet for roughly a third of each burst. A pair that arrives while the previous one is still being sent waits in a single holding slot. A further pair that finds that slot occupied is dropped, and a sticky flag records the loss. When the burst-active input falls, all queued work is discarded at once and the line goes quiet.

Top module: `iq_word_serializer`

## Requirements
- R1: The in-phase word is the 15-bit I sample in bits 15:1, with bit 0 equal to 0.
- R2: The quadrature word is the 15-bit Q sample in bits 15:1, with bit 0 equal to 1.
- R3: For each pair the I word is sent first. The Q word's bit 15 follows in the clock right after the I word's bit 0.
- R4: Words are sent MSB first, one bit per clock, and `bit_en` is high exactly in the clocks that carry a data bit.
- R5: `word_sync` is high for one clock, in the clock just before bit 15 of every word. For a pair accepted on clock edge k into an idle block, `word_sync` is high after edge k+1 and bit 15 of the I word appears after edge k+2.
- R6: Whenever `bit_en` is low, `ser_out` is low.
- R7: A pair that arrives while another is being sent is held and sent afterwards. Its I word bit 15 follows directly after the previous Q word bit 0, so a pair strobed one clock after an accepted pair starts 32 clocks after the earlier pair's first bit.
- R8: A pair that arrives while one pair is in flight and another is held is dropped, and `overrun` goes high. `overrun` stays high until `burst_on` is sampled low.
- R9: When `burst_on` is sampled low, the pair being sent and any held pair are discarded. After that edge `ser_out`, `word_sync` and `bit_en` are low, and strobes seen while `burst_on` is low are ignored.
- R10: While `rst` is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| burst_on | input | 1 | High while a burst is being received |
| pair_stb | input | 1 | One-clock strobe: a new I/Q pair is present |
| i_smp | input | 15 | In-phase sample |
| q_smp | input | 15 | Quadrature sample |
| ser_out | output | 1 | Serial data, MSB first |
| word_sync | output | 1 | One-clock pulse before each word's first bit |
| bit_en | output | 1 | High while `ser_out` carries a data bit |
| overrun | output | 1 | Sticky flag: a pair was dropped |

## Verification
Pairs spaced 33 to 90 clocks apart, with random sample values, test packing and bit order alone, since the holding slot is never needed. Pairs strobed on adjacent clocks separate a design that uses the holding slot and chains words with no gap from one that leaves a gap or loses the second pair. Three adjacent strobes tell apart dropping the newest pair from overwriting the held one, and both from losing the overrun indication. Dropping `burst_on` mid-word with a pair held, and strobing while the burst is off, shows whether stale data is ever sent.

// File: rtl/iq_ser_pkg.sv
package iq_ser_pkg;
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_SYNC  = 2'd1,
    SH_SHIFT = 2'd2
  } sh_state_e;

  localparam logic TAG_I = 1'b0;
  localparam logic TAG_Q = 1'b1;
endpackage

// File: rtl/iq_pair_hold.sv
module iq_pair_hold #(
  parameter int SMP_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             burst_on,
  input  logic             pair_stb,
  input  logic [SMP_W-1:0] i_in,
  input  logic [SMP_W-1:0] q_in,
  input  logic             take,
  output logic             avail,
  output logic [SMP_W-1:0] i_out,
  output logic [SMP_W-1:0] q_out,
  output logic             ovf
);
  logic             slot_v;
  logic [SMP_W-1:0] slot_i;
  logic [SMP_W-1:0] slot_q;
  logic             load;

  // a strobe fills the slot if it is empty or being emptied this edge
  assign load = burst_on && pair_stb && (!slot_v || take);

  always_ff @(posedge clk) begin
    if (rst || !burst_on) begin
      slot_v <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (load)
        slot_v <= 1'b1;
      else if (take)
        slot_v <= 1'b0;
      if (pair_stb && slot_v && !take)
        ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      slot_i <= i_in;
      slot_q <= q_in;
    end
  end

  assign avail = slot_v;
  assign i_out = slot_i;
  assign q_out = slot_q;
endmodule

// File: rtl/iq_word_pack.sv
module iq_word_pack #(
  parameter int SMP_W = 15,
  localparam int PAIR_W = 2 * (SMP_W + 1)
) (
  input  logic [SMP_W-1:0]  i_s,
  input  logic [SMP_W-1:0]  q_s,
  output logic [PAIR_W-1:0] pair_word
);
  import iq_ser_pkg::*;

  // I word occupies the upper half, so it leaves the shifter first
  assign pair_word = {i_s, TAG_I, q_s, TAG_Q};
endmodule

// File: rtl/iq_word_shift.sv
module iq_word_shift #(
  parameter int WORD_W = 16,
  localparam int PAIR_W = 2 * WORD_W,
  localparam int CNT_W = $clog2(PAIR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_on,
  input  logic              avail,
  input  logic [PAIR_W-1:0] pair_word,
  output logic              take,
  output logic              sdo,
  output logic              fsync,
  output logic              bclk_en
);
  import iq_ser_pkg::*;

  sh_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [PAIR_W-1:0] shreg;
  logic              last_bit;

  assign last_bit = (st == SH_SHIFT) && (cnt == CNT_W'(PAIR_W - 1));
  assign take     = burst_on && avail && ((st == SH_IDLE) || last_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SH_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      sdo     <= 1'b0;
      fsync   <= 1'b0;
      bclk_en <= 1'b0;
    end else if (!burst_on) begin
      st      <= SH_IDLE;
      sdo     <= 1'b0;
      fsync   <= 1'b0;
      bclk_en <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: begin
          sdo     <= 1'b0;
          bclk_en <= 1'b0;
          fsync   <= take;
          if (take) begin
            shreg <= pair_word;
            st    <= SH_SYNC;
          end
        end
        SH_SYNC: begin
          sdo     <= shreg[PAIR_W-1];
          shreg   <= {shreg[PAIR_W-2:0], 1'b0};
          bclk_en <= 1'b1;
          fsync   <= 1'b0;
          cnt     <= CNT_W'(1);
          st      <= SH_SHIFT;
        end
        SH_SHIFT: begin
          sdo     <= shreg[PAIR_W-1];
          bclk_en <= 1'b1;
          cnt     <= cnt + 1'b1;
          // sync for the Q word rides on I bit 0; sync for a chained pair rides on Q bit 0
          fsync   <= (cnt == CNT_W'(WORD_W - 1)) || take;
          if (take) begin
            shreg <= pair_word;
            st    <= SH_SYNC;
          end else begin
            shreg <= {shreg[PAIR_W-2:0], 1'b0};
            if (last_bit)
              st <= SH_IDLE;
          end
        end
        default: begin
          st      <= SH_IDLE;
          sdo     <= 1'b0;
          fsync   <= 1'b0;
          bclk_en <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/iq_word_serializer.sv
module iq_word_serializer #(
  parameter int SMP_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             burst_on,
  input  logic             pair_stb,
  input  logic [SMP_W-1:0] i_smp,
  input  logic [SMP_W-1:0] q_smp,
  output logic             ser_out,
  output logic             word_sync,
  output logic             bit_en,
  output logic             overrun
);
  localparam int WORD_W = SMP_W + 1;
  localparam int PAIR_W = 2 * WORD_W;

  logic              avail;
  logic              take;
  logic [SMP_W-1:0]  hold_i;
  logic [SMP_W-1:0]  hold_q;
  logic [PAIR_W-1:0] pair_word;

  iq_pair_hold #(.SMP_W(SMP_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .burst_on (burst_on),
    .pair_stb (pair_stb),
    .i_in     (i_smp),
    .q_in     (q_smp),
    .take     (take),
    .avail    (avail),
    .i_out    (hold_i),
    .q_out    (hold_q),
    .ovf      (overrun)
  );

  iq_word_pack #(.SMP_W(SMP_W)) u_pack (
    .i_s       (hold_i),
    .q_s       (hold_q),
    .pair_word (pair_word)
  );

  iq_word_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .burst_on  (burst_on),
    .avail     (avail),
    .pair_word (pair_word),
    .take      (take),
    .sdo       (ser_out),
    .fsync     (word_sync),
    .bclk_en   (bit_en)
  );
endmodule

// File: rtl/iq_ser_chk.sv
module iq_ser_chk (
  input logic clk,
  input logic rst,
  input logic burst_on,
  input logic ser_out,
  input logic word_sync,
  input logic bit_en,
  input logic overrun
);
  // R6: data line is quiet outside data bits
  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !bit_en |-> !ser_out);

  // R9: burst end silences every output on the next cycle
  a_r9_burst_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !burst_on |=> (!bit_en && !word_sync && !ser_out));

  // R5: sync is a single-cycle pulse
  a_r5_sync_single: assert property (@(posedge clk) disable iff (rst)
    word_sync |=> !word_sync);

  // R5: a sync during a burst is followed by a data bit
  a_r5_sync_then_data: assert property (@(posedge clk) disable iff (rst)
    (word_sync && burst_on) |=> bit_en);

  // R8: overrun is sticky while the burst lasts
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && burst_on) |=> overrun);

  // R8: burst end clears overrun
  a_r8_ovf_cleared: assert property (@(posedge clk) disable iff (rst)
    !burst_on |=> !overrun);
endmodule

bind iq_word_serializer iq_ser_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .burst_on  (burst_on),
  .ser_out   (ser_out),
  .word_sync (word_sync),
  .bit_en    (bit_en),
  .overrun   (overrun)
);

// File: tb/sim_iq_word_serializer.sv
module sim_iq_word_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        burst_on = 1'b0;
  logic        pair_stb = 1'b0;
  logic [14:0] i_smp = '0;
  logic [14:0] q_smp = '0;
  logic        ser_out, word_sync, bit_en, overrun;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  int        bp = -1;
  logic [15:0] sh = '0;
  int        t0 = 0;
  logic [15:0] rx_w[$];
  int        rx_t[$];
  logic [15:0] exp_w[$];
  int        stray = 0;
  int        idle_err = 0;

  iq_word_serializer u0 (
    .clk(clk), .rst(rst), .burst_on(burst_on), .pair_stb(pair_stb),
    .i_smp(i_smp), .q_smp(q_smp), .ser_out(ser_out), .word_sync(word_sync),
    .bit_en(bit_en), .overrun(overrun)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] mkw(input logic [14:0] s, input logic tag);
    return {s, tag};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // serial receiver: a word starts one clock after word_sync
  always @(negedge clk) begin
    if (rst) begin
      bp = -1;
    end else begin
      if (!bit_en && ser_out) idle_err++;
      if (bp >= 0) begin
        if (!bit_en) begin
          bp = -1;
        end else begin
          if (bp == 0) t0 = cyc;
          sh = {sh[14:0], ser_out};
          bp++;
          if (bp == 16) begin
            rx_w.push_back(sh);
            rx_t.push_back(t0);
            bp = -1;
          end
        end
      end else if (bit_en) begin
        stray++;
      end
      if (word_sync) bp = 0;
    end
  end

  task automatic compare_rx(input string req);
    check(rx_w.size() == exp_w.size(), req, rx_w.size(), exp_w.size());
    while (rx_w.size() > 0 && exp_w.size() > 0) begin
      logic [15:0] a, e;
      a = rx_w.pop_front();
      e = exp_w.pop_front();
      check(a == e, req, a, e);
    end
    rx_w.delete(); rx_t.delete(); exp_w.delete();
  endtask

  task automatic put(input logic [14:0] iv, input logic [14:0] qv, input bit expect_sent);
    pair_stb = 1'b1; i_smp = iv; q_smp = qv;
    if (expect_sent) begin
      exp_w.push_back(mkw(iv, 1'b0));
      exp_w.push_back(mkw(qv, 1'b1));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1));
    // R10: reset state
    repeat (3) @(negedge clk);
    check({ser_out, word_sync, bit_en, overrun} == 4'b0, "R10", {ser_out, word_sync, bit_en, overrun}, 0);
    rst = 1'b0; burst_on = 1'b1;
    repeat (2) @(negedge clk);

    // R5/R4/R1/R2: single pair latency and format
    put(15'h4B2D, 15'h1234, 1'b1);
    @(negedge clk); pair_stb = 1'b0;
    check(word_sync == 1'b0, "R5 early", word_sync, 0);
    @(negedge clk);
    check(word_sync == 1'b1, "R5 sync", word_sync, 1);
    check(bit_en == 1'b0, "R4 en before data", bit_en, 0);
    @(negedge clk);
    check(bit_en == 1'b1, "R4 en on bit15", bit_en, 1);
    check(ser_out == 1'b1, "R4 msb first", ser_out, 1);
    repeat (40) @(negedge clk);
    check(rx_t.size() == 2 && rx_t[1] - rx_t[0] == 16, "R3 no gap", rx_t.size() == 2 ? rx_t[1] - rx_t[0] : -1, 16);
    compare_rx("R1 R2 single");

    // R7: two pairs on adjacent clocks
    put(15'h7FFF, 15'h0000, 1'b1);
    @(negedge clk); put(15'h0001, 15'h5555, 1'b1);
    @(negedge clk); pair_stb = 1'b0;
    repeat (80) @(negedge clk);
    check(rx_t.size() == 4 && rx_t[2] - rx_t[0] == 32, "R7 chained", rx_t.size() == 4 ? rx_t[2] - rx_t[0] : -1, 32);
    check(overrun == 1'b0, "R8 no overrun", overrun, 0);
    compare_rx("R7 words");

    // R8: third pair dropped
    put(15'h0F0F, 15'h7070, 1'b1);
    @(negedge clk); put(15'h2222, 15'h3333, 1'b1);
    @(negedge clk); put(15'h6666, 15'h1111, 1'b0);
    @(negedge clk); pair_stb = 1'b0;
    check(overrun == 1'b1, "R8 set", overrun, 1);
    repeat (80) @(negedge clk);
    check(overrun == 1'b1, "R8 sticky", overrun, 1);
    compare_rx("R8 drop newest");
    burst_on = 1'b0;
    @(negedge clk);
    check(overrun == 1'b0, "R8 clear", overrun, 0);
    burst_on = 1'b1;
    @(negedge clk);

    // R9: burst ends mid-word with a pair held
    put(15'h7FFF, 15'h7FFF, 1'b0);
    @(negedge clk); put(15'h7FFF, 15'h7FFF, 1'b0);
    @(negedge clk); pair_stb = 1'b0;
    repeat (8) @(negedge clk);
    check(bit_en == 1'b1, "R9 sending", bit_en, 1);
    burst_on = 1'b0;
    @(negedge clk);
    check({ser_out, word_sync, bit_en} == 3'b0, "R9 quiet", {ser_out, word_sync, bit_en}, 0);
    put(15'h1357, 15'h2468, 1'b0);
    @(negedge clk); pair_stb = 1'b0;
    burst_on = 1'b1;
    repeat (80) @(negedge clk);
    check(rx_w.size() == 0, "R9 discarded", rx_w.size(), 0);
    compare_rx("R9 none");

    // R1 R2 R3 R4: random pairs, spacing keeps the slot free
    for (int k = 0; k < 40; k++) begin
      put(15'($urandom), 15'($urandom), 1'b1);
      @(negedge clk); pair_stb = 1'b0;
      repeat ((k % 4 == 0) ? 47 : $urandom_range(32, 89)) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    compare_rx("R1 R2 R3 random");
    check(overrun == 1'b0, "R8 random", overrun, 0);
    check(idle_err == 0, "R6 idle low", idle_err, 0);
    check(stray == 0, "R4 stray enable", stray, 0);
    finish_run();
  end
endmodule